// File: doc/BRIEF.md
# PCM Serial Voice Port

This block is the digital side of a telephone codec's sample path. Each direction carries one 8-bit companded voice sample per 8 kHz frame. On the transmit side a parallel byte is latched when the slot opens and is shifted out most-significant bit first. The block pulls an active-low slot indicator for the length of the slot and releases the data output at every other time. On the receive side serial bits are sampled on falling bit-clock edges after the receive sync, and the finished byte is presented with a one-cycle strobe.

The bit clock, sync and serial data inputs are asynchronous to the system clock. Each one passes through a short synchronizer, and the block acts on the edges it detects there. A mode input selects short-frame sync, where the sync pulse is seen at a falling bit-clock edge, or long-frame sync, where the sync's rising edge opens the slot. A second input lets the receiver run from the transmit bit clock instead of its own.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, ts_n_o is 1, tx_oe_o is 0, tx_data_o is 0, rx_valid_o is 0 and rx_byte_o is 0.
- R2: In short-frame mode (long_frame_i=0), the slot starts at the first rising bit-clock edge after a falling edge where sync is high and was low at the previous falling edge. At the start, tx_oe_o goes to 1, ts_n_o goes to 0 and bit 7 is driven. Each later rising edge drives the next lower bit.
- R3: The slot ends at the falling bit-clock edge that follows the eighth bit: tx_oe_o goes to 0, ts_n_o to 1 and tx_data_o to 0. Further bit clocks in the frame leave the output released.
- R4: tx_byte_i is captured when the slot starts. Changing it during the slot does not alter the bits shifted out.
- R5: In long-frame mode (long_frame_i=1), bit 7 becomes valid at the later of two events: the sync's rising edge or the transmit bit clock's rising edge. The remaining bits follow on later rising edges.
- R6: A short sync that stays high for two bit-clock periods opens exactly one slot, the same as a one-period sync.
- R7: In short-frame mode, the receiver samples rx_data_i on the eight falling edges that follow the falling edge at which sync was detected. The first sample is bit 7. It then updates rx_byte_o and pulses rx_valid_o for one system clock.
- R8: In long-frame mode, the receiver samples on the eight falling edges starting with the first one after the sync's rising edge.
- R9: With shared_bclk_i=1 the receiver is clocked by bclk_tx_i and bclk_rx_i is ignored. With shared_bclk_i=0 and bclk_rx_i idle, no byte is received.
- R10: rx_byte_o holds its value between rx_valid_o pulses.
- R11: A sync pulse arriving while a transmit slot or a receive byte is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| long_frame_i | input | 1 | 1 selects long-frame sync, 0 selects short-frame sync |
| shared_bclk_i | input | 1 | 1 makes the receiver use the transmit bit clock |
| bclk_tx_i | input | 1 | Transmit bit clock |
| fs_tx_i | input | 1 | Transmit frame sync |
| tx_byte_i | input | 8 | Sample to send, captured at slot start |
| tx_data_o | output | 1 | Serial data out, 0 while released |
| tx_oe_o | output | 1 | Serial output enable; 0 means high impedance |
| ts_n_o | output | 1 | Slot indicator: 0 pulls low, 1 releases |
| bclk_rx_i | input | 1 | Receive bit clock |
| fs_rx_i | input | 1 | Receive frame sync |
| rx_data_i | input | 1 | Serial data in |
| rx_byte_o | output | 8 | Last received sample |
| rx_valid_o | output | 1 | One-cycle strobe when rx_byte_o updates |

## Verification
The hardest cases to reach are those where sync edges fall inside an open slot or byte, and the long-frame case where sync rises while the bit clock is already high. In that case the first bit must come from the sync edge and not from a clock edge. The bench builds every frame from explicit half-period steps. It can therefore place the sync rise in either clock phase, stretch a short sync to two periods, inject a stray sync pulse mid-slot, and rewrite the transmit byte after capture. All 256 transmit values are swept in short mode, and a range of receive patterns is applied alongside them.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    SYNC_SHORT = 1'b0,
    SYNC_LONG  = 1'b1
  } sync_mode_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_ev_t;
endpackage

// File: rtl/pcm_line_sampler.sv
module pcm_line_sampler
  import pcm_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     d_i,
  output line_ev_t ev_o
);
  logic [STAGES-1:0] pipe_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= (pipe_q << 1) | STAGES'(d_i);
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign ev_o.lvl  = pipe_q[STAGES-1];
  assign ev_o.rise = pipe_q[STAGES-1] & ~last_q;
  assign ev_o.fall = ~pipe_q[STAGES-1] & last_q;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sync_mode_e   mode_i,
  input  line_ev_t     bclk_i,
  input  line_ev_t     fs_i,
  input  logic [W-1:0] byte_i,
  output logic         data_o,
  output logic         oe_o,
  output logic         ts_n_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          active_q, fs_at_fall_q, short_arm_q, long_pend_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic          is_long, short_hit, long_now, start, last_bit;

  assign is_long   = (mode_i == SYNC_LONG);
  assign short_hit = !is_long && bclk_i.fall && fs_i.lvl && !fs_at_fall_q;
  // long frame: sync rising while clock already high opens the slot at once
  assign long_now  = is_long && fs_i.rise && bclk_i.lvl;
  assign start     = !active_q &&
                     ((!is_long && short_arm_q && bclk_i.rise) ||
                      long_now ||
                      (is_long && long_pend_q && bclk_i.rise));
  assign last_bit  = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      fs_at_fall_q <= 1'b0;
      short_arm_q  <= 1'b0;
      long_pend_q  <= 1'b0;
      cnt_q        <= '0;
      sh_q         <= '0;
    end else begin
      if (bclk_i.fall) fs_at_fall_q <= fs_i.lvl;

      if (start || is_long)                short_arm_q <= 1'b0;
      else if (short_hit && !active_q)     short_arm_q <= 1'b1;

      if (start || !is_long || !fs_i.lvl)  long_pend_q <= 1'b0;
      else if (fs_i.rise && !bclk_i.lvl && !active_q) long_pend_q <= 1'b1;

      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        sh_q     <= byte_i;
      end else if (active_q) begin
        if (bclk_i.rise && !last_bit) begin
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q + 1'b1;
        end else if (bclk_i.fall && last_bit) begin
          active_q <= 1'b0;
        end
      end
    end
  end

  assign data_o = active_q & sh_q[W-1];
  assign oe_o   = active_q;
  assign ts_n_o = ~active_q;
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sync_mode_e   mode_i,
  input  line_ev_t     bclk_i,
  input  line_ev_t     fs_i,
  input  logic         din_i,
  output logic [W-1:0] byte_o,
  output logic         valid_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, fs_at_fall_q, valid_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q, byte_q, next_sh;
  logic          arm;

  assign arm = !busy_q &&
               ((mode_i == SYNC_LONG) ? fs_i.rise
                                      : (bclk_i.fall && fs_i.lvl && !fs_at_fall_q));
  assign next_sh = (sh_q << 1) | W'(din_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      fs_at_fall_q <= 1'b0;
      valid_q      <= 1'b0;
      cnt_q        <= '0;
      sh_q         <= '0;
      byte_q       <= '0;
    end else begin
      valid_q <= 1'b0;
      if (bclk_i.fall) fs_at_fall_q <= fs_i.lvl;
      if (arm) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && bclk_i.fall) begin
        sh_q  <= next_sh;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q  <= 1'b0;
          byte_q  <= next_sh;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                long_frame_i,
  input  logic                shared_bclk_i,
  input  logic                bclk_tx_i,
  input  logic                fs_tx_i,
  input  logic [SAMPLE_W-1:0] tx_byte_i,
  output logic                tx_data_o,
  output logic                tx_oe_o,
  output logic                ts_n_o,
  input  logic                bclk_rx_i,
  input  logic                fs_rx_i,
  input  logic                rx_data_i,
  output logic [SAMPLE_W-1:0] rx_byte_o,
  output logic                rx_valid_o
);
  localparam int NLINES  = 5;
  localparam int L_TXCLK = 0;
  localparam int L_TXFS  = 1;
  localparam int L_RXCLK = 2;
  localparam int L_RXFS  = 3;
  localparam int L_RXD   = 4;

  logic [NLINES-1:0] raw;
  line_ev_t          ev [NLINES];
  line_ev_t          tx_bclk_ev, tx_fs_ev, rx_bclk_ev;
  sync_mode_e        mode;

  assign raw = {rx_data_i, fs_rx_i, bclk_rx_i, fs_tx_i, bclk_tx_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    pcm_line_sampler #(.STAGES(SYNC_STAGES)) u_smp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .ev_o  (ev[g])
    );
  end

  assign mode       = long_frame_i ? SYNC_LONG : SYNC_SHORT;
  assign tx_bclk_ev = ev[L_TXCLK];
  assign tx_fs_ev   = ev[L_TXFS];
  assign rx_bclk_ev = shared_bclk_i ? ev[L_TXCLK] : ev[L_RXCLK];

  pcm_tx_lane #(.W(SAMPLE_W)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .bclk_i(tx_bclk_ev),
    .fs_i  (tx_fs_ev),
    .byte_i(tx_byte_i),
    .data_o(tx_data_o),
    .oe_o  (tx_oe_o),
    .ts_n_o(ts_n_o)
  );

  pcm_rx_lane #(.W(SAMPLE_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .bclk_i (rx_bclk_ev),
    .fs_i   (ev[L_RXFS]),
    .din_i  (ev[L_RXD].lvl),
    .byte_o (rx_byte_o),
    .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tx_oe_o,
  input logic                ts_n_o,
  input logic                tx_data_o,
  input logic                rx_valid_o,
  input logic [SAMPLE_W-1:0] rx_byte_o,
  input logic                tx_rise_i,
  input logic                tx_fall_i,
  input logic                tx_fs_rise_i
);
  logic [7:0] rises_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rises_q <= '0;
    else if (!tx_oe_o)         rises_q <= '0;
    else if (tx_rise_i && rises_q != 8'hff) rises_q <= rises_q + 1'b1;
  end

  // R3: no more than SAMPLE_W-1 shifts inside one slot
  assert_slot_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> (rises_q <= 8'(SAMPLE_W - 1)));

  assert_end_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_oe_o) |-> $past(tx_fall_i));

  // R2 / R5: a slot opens only on a clock rise or a sync rise
  assert_start_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe_o) |-> $past(tx_rise_i || tx_fs_rise_i));

  assert_bit_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_oe_o && $past(tx_oe_o) && !$past(tx_rise_i)) |-> $stable(tx_data_o));

  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_n_o |-> (!tx_oe_o && !tx_data_o));

  assert_strobe_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_byte_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_byte_o) |-> rx_valid_o);
endmodule

bind pcm_voice_port pcm_voice_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_oe_o     (tx_oe_o),
  .ts_n_o      (ts_n_o),
  .tx_data_o   (tx_data_o),
  .rx_valid_o  (rx_valid_o),
  .rx_byte_o   (rx_byte_o),
  .tx_rise_i   (tx_bclk_ev.rise),
  .tx_fall_i   (tx_bclk_ev.fall),
  .tx_fs_rise_i(tx_fs_ev.rise)
);

// File: tb/pcm_voice_port_test.sv
module pcm_voice_port_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       long_frame_i = 1'b0, shared_bclk_i = 1'b0;
  logic       bclk_tx_i = 1'b0, fs_tx_i = 1'b0, bclk_rx_i = 1'b0, fs_rx_i = 1'b0;
  logic       rx_data_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic       tx_data_o, tx_oe_o, ts_n_o, rx_valid_o;
  logic [7:0] rx_byte_o;

  int checks = 0, errors = 0, vcount = 0;
  logic [7:0] last_rx = '0;
  logic       rxclk_en = 1'b1;

  always #2 clk = ~clk;

  pcm_voice_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .long_frame_i(long_frame_i),
    .shared_bclk_i(shared_bclk_i), .bclk_tx_i(bclk_tx_i), .fs_tx_i(fs_tx_i),
    .tx_byte_i(tx_byte_i), .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o),
    .ts_n_o(ts_n_o), .bclk_rx_i(bclk_rx_i), .fs_rx_i(fs_rx_i),
    .rx_data_i(rx_data_i), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) if (rx_valid_o) begin
    vcount  <= vcount + 1;
    last_rx <= rx_byte_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_bclk(input logic v);
    bclk_tx_i = v;
    bclk_rx_i = rxclk_en ? v : 1'b0;
  endtask

  task automatic set_fs(input logic v);
    fs_tx_i = v;
    fs_rx_i = v;
  endtask

  // One frame: period -1 carries the short sync, periods 0..7 the slot, 8..9 idle
  task automatic run_frame(input bit lng, input bit fs_low_phase, input int fs_periods,
                           input bit shared, input bit rxclk_on, input bit glitch,
                           input logic [7:0] txb, input logic [7:0] rxb);
    int    v0;
    string ttag, rtag;
    logic [7:0] prev_rx;
    v0       = vcount;
    prev_rx  = rx_byte_o;
    ttag     = lng ? "R5" : (glitch ? "R11" : (fs_periods == 2 ? "R6" : "R2"));
    rtag     = shared ? "R9" : (lng ? "R8" : (glitch ? "R11" : "R7"));
    long_frame_i  = lng;
    shared_bclk_i = shared;
    rxclk_en      = rxclk_on;
    tx_byte_i     = txb;
    set_bclk(1'b1); step(1);
    if (!lng) set_fs(1'b1);
    step(4);
    chk(tx_oe_o == 1'b0 && ts_n_o == 1'b1, "R2 idle before slot", int'(tx_oe_o), 0);
    step(1);
    set_bclk(1'b0); step(1);
    if (lng && fs_low_phase) set_fs(1'b1);
    step(5);
    for (int k = 0; k < 10; k++) begin
      set_bclk(1'b1); step(1);
      if (lng && !fs_low_phase && k == 0) set_fs(1'b1);
      rx_data_i = (k < 8) ? rxb[7-k] : 1'b0;
      if (k == 1) tx_byte_i = ~txb;
      if (!lng && k == fs_periods - 1) set_fs(1'b0);
      if (lng && k == 4) set_fs(1'b0);
      if (glitch && k == 3) set_fs(1'b1);
      if (glitch && k == 4) set_fs(1'b0);
      step(4);
      if (k < 8) begin
        chk(tx_oe_o == 1'b1 && ts_n_o == 1'b0, ttag, int'(tx_oe_o), 1);
        chk(tx_data_o == txb[7-k], ttag, int'(tx_data_o), int'(txb[7-k]));
        if (k >= 2) chk(tx_data_o == txb[7-k], "R4", int'(tx_data_o), int'(txb[7-k]));
      end else begin
        chk(tx_oe_o == 1'b0 && ts_n_o == 1'b1 && tx_data_o == 1'b0, "R3 extra clocks",
            int'(tx_oe_o), 0);
      end
      step(1);
      set_bclk(1'b0); step(5);
      if (k == 7)
        chk(tx_oe_o == 1'b0 && ts_n_o == 1'b1, "R3 release after fall", int'(tx_oe_o), 0);
    end
    step(6);
    if (rxclk_on || shared) begin
      chk(vcount - v0 == 1, rtag, vcount - v0, 1);
      chk(rx_byte_o == rxb, rtag, int'(rx_byte_o), int'(rxb));
      chk(last_rx == rxb, "R7 strobe byte", int'(last_rx), int'(rxb));
    end else begin
      chk(vcount - v0 == 0, "R9 idle rx clock", vcount - v0, 0);
      chk(rx_byte_o == prev_rx, "R10 hold", int'(rx_byte_o), int'(prev_rx));
    end
    step(12);
    chk(rx_byte_o == ((rxclk_on || shared) ? rxb : prev_rx), "R10 hold after frame",
        int'(rx_byte_o), int'((rxclk_on || shared) ? rxb : prev_rx));
  endtask

  initial begin
    step(5);
    chk(ts_n_o == 1'b1 && tx_oe_o == 1'b0 && tx_data_o == 1'b0, "R1 tx reset",
        int'(tx_oe_o), 0);
    chk(rx_valid_o == 1'b0 && rx_byte_o == 8'h00, "R1 rx reset", int'(rx_byte_o), 0);
    rst_ni = 1'b1;
    step(10);
    for (int i = 0; i < 256; i++)
      run_frame(1'b0, 1'b0, 1 + (i % 2), 1'b0, 1'b1, (i % 16) == 5,
                8'(i), 8'(i * 37 + 11));
    for (int i = 0; i < 32; i++)
      run_frame(1'b1, i[0], 1, 1'b0, 1'b1, 1'b0, 8'(i * 7 + 3), 8'(~(i * 13)));
    for (int i = 0; i < 4; i++)
      run_frame(i[0], 1'b1, 1, 1'b1, 1'b0, 1'b0, 8'(i * 61), 8'(i * 45 + 9));
    for (int i = 0; i < 2; i++)
      run_frame(i[0], 1'b0, 1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule